// File: doc/BRIEF.md
# Four-Channel Programmable DMA Controller

This block moves data words between peripherals and memory without the processor handling each word. Software programs each of four channels through a small register port: a current address, a word count and a mode word. A peripheral raises its channel's request line. The controller picks the winning channel by fixed priority and asks the processor to release the bus. Once the processor acknowledges, the controller drives the memory address and one read or write strobe. It acknowledges the peripheral and then steps that channel's address and count.

The count is loaded as the number of words minus one. The word that finds the count at zero is the last one: the controller raises end-of-process during that word's strobe, the count rolls over to FFFFh, and the channel stops until software writes a new count. A sticky terminal-count flag per channel can raise an interrupt. Channels 0 and 1 can also be paired to copy a block from one memory range to another. The copy reads a word into an internal holding register and then writes it out. The destination channel's count ends the block.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, hold_req, dack, mem_rd, mem_wr, eop and irq are low, and every address, count and mode register reads zero.
- R2: cfg_addr[3:2] selects the channel and cfg_addr[1:0] selects the field: 0 is the 24-bit address, 1 is the 16-bit count and 2 is the mode. A write with cfg_wr loads the field, and cfg_rdata returns it without delay.
- R3: Mode bit 0 enables a channel. A channel takes part only if it is enabled, its request is high and it has not reached terminal count. Among those channels, the lowest-numbered one is served first. A request on a disabled channel leaves its registers and the bus untouched.
- R4: No strobe and no acknowledge appear until hold_ack is high. hold_req stays high from the request until the transfer ends.
- R5: A peripheral word is a single strobe cycle carrying mem_addr equal to the channel's current address. Mode bit 2 set gives mem_rd (memory to peripheral) and clear gives mem_wr. The channel's dack bit is high during the strobe.
- R6: After each word the address steps by one: up when mode bit 1 is clear, down when it is set. It wraps within 24 bits.
- R7: After each word the count drops by one. A word issued with count 0 raises eop during its strobe and leaves the count at FFFFh. The channel then ignores its request until its count is written again.
- R8: dack stays high after the strobe until the peripheral drops its request. dack and hold_req fall on the next cycle.
- R9: With mode bit 4 of channel 0 set, a channel 0 request copies a block. Each word is a read at channel 0's address followed by a write of that data at channel 1's address, and both addresses step. Only channel 1's count is decremented and it decides the end. eop marks the last write, and the bus stays held until then.
- R10: Field 3 reads the status word: bits 3:0 are terminal-count flags and bits 7:4 are the stopped channels. A status read with cfg_rd clears the flags. irq is high while any flag is set on a channel whose mode bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (clears flags on status read) |
| cfg_addr | input | 4 | Channel and field select |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Register read data |
| dreq | input | 4 | Per-channel peripheral request |
| dack | output | 4 | Per-channel acknowledge |
| hold_req | output | 1 | Bus request to processor |
| hold_ack | input | 1 | Bus granted by processor |
| mem_addr | output | 24 | Memory address during a strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data (copy mode) |
| mem_wdata | output | 8 | Memory write data (copy mode) |
| eop | output | 1 | End of process, high during the last word's strobe |
| irq | output | 1 | Interrupt request |

## Verification
The checks assume that the processor raises hold_ack only in reply to hold_req and keeps it high while hold_req stays high. They also assume that a peripheral holds its request until it has seen its acknowledge. The processor model in the stimulus registers hold_req into hold_ack, so the grant always follows the request. Each peripheral request stays high until the stimulus has sampled the strobe and the held acknowledge. Register writes are issued only while the bus is idle, so software writes never collide with an address or count step.

// File: rtl/dma4_pkg.sv
// Shared constants and types for the four-channel DMA controller.
// Assumes register fields are selected by a two-bit code and that mode
// bits sit at the positions listed here.
package dma4_pkg;
    localparam logic [1:0] FLD_ADDR = 2'd0;
    localparam logic [1:0] FLD_CNT  = 2'd1;
    localparam logic [1:0] FLD_MODE = 2'd2;
    localparam logic [1:0] FLD_STAT = 2'd3;

    localparam int MB_EN   = 0;  // channel enable
    localparam int MB_DEC  = 1;  // address steps down
    localparam int MB_RD   = 2;  // memory read toward peripheral
    localparam int MB_IRQ  = 3;  // interrupt unmask
    localparam int MB_M2M  = 4;  // block copy (channel 0 only)
    localparam int MODE_W  = 5;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HOLD,
        S_XFER,
        S_ACKW,
        S_MRD,
        S_MWR
    } seq_state_t;
endpackage

// File: rtl/dma_chan_regs.sv
// One channel's programmable state: current address, word count, mode
// and a stopped flag. A bus step has priority over a software write;
// software is assumed to write only while the bus is idle.
module dma_chan_regs
    import dma4_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_addr,
    input  logic              wr_cnt,
    input  logic              wr_mode,
    input  logic [AW-1:0]     wdata,
    input  logic              step_addr,
    input  logic              step_cnt,
    input  logic              force_done,
    output logic [AW-1:0]     cur_addr,
    output logic [CW-1:0]     cur_cnt,
    output logic [MODE_W-1:0] mode,
    output logic              done,
    output logic              tc
);
    // Terminal count: a counted word that starts from zero.
    assign tc = step_cnt && (cur_cnt == '0);

    // Address register: load from software or step after a word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (step_addr)
            cur_addr <= mode[MB_DEC] ? cur_addr - AW'(1) : cur_addr + AW'(1);
        else if (wr_addr)
            cur_addr <= wdata;
    end

    // Count register: load from software or decrement after a word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_cnt <= '0;
        else if (step_cnt)
            cur_cnt <= cur_cnt - CW'(1);
        else if (wr_cnt)
            cur_cnt <= wdata[CW-1:0];
    end

    // Mode register: software only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= '0;
        else if (wr_mode)
            mode <= wdata[MODE_W-1:0];
    end

    // Stopped flag: set at terminal count, cleared by a new count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (tc || force_done)
            done <= 1'b1;
        else if (wr_cnt)
            done <= 1'b0;
    end
endmodule

// File: rtl/dma_prio.sv
// Fixed-priority selector: the lowest set request index wins.
// Assumes N is at least 2.
module dma_prio #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    // Scan from the top down so the lowest index is written last.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/dma_seq.sv
// Transfer sequencer: requests the bus, runs one peripheral word or a
// read/write copy loop, and waits for the request to drop. It arbitrates
// only in the idle state, so no word is ever interrupted.
module dma_seq
    import dma4_pkg::*;
#(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pick_any,
    input  logic [IW-1:0] pick_idx,
    input  logic          pick_m2m,
    input  logic          hold_ack,
    input  logic          dreq_cur,
    input  logic          last_dst,
    output seq_state_t    st,
    output logic [IW-1:0] cur_ch
);
    logic copy_q;

    // State, latched channel and copy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            cur_ch <= '0;
            copy_q <= 1'b0;
        end else begin
            case (st)
                S_IDLE: if (pick_any) begin
                    st     <= S_HOLD;
                    cur_ch <= pick_idx;
                    copy_q <= pick_m2m;
                end
                S_HOLD: if (hold_ack) st <= copy_q ? S_MRD : S_XFER;
                S_XFER: st <= S_ACKW;
                S_ACKW: if (!dreq_cur) st <= S_IDLE;
                S_MRD:  st <= S_MWR;
                S_MWR:  st <= last_dst ? S_IDLE : S_MRD;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma4_ctrl.sv
// Four-channel DMA controller top. It decodes the register port, holds
// the per-channel registers, arbitrates, sequences the bus and raises
// eop and irq. Assumes the processor grants the bus only after hold_req
// and that software leaves the registers alone while the bus is held.
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int N  = 4,
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_wr,
    input  logic          cfg_rd,
    input  logic [IW+1:0] cfg_addr,
    input  logic [AW-1:0] cfg_wdata,
    output logic [AW-1:0] cfg_rdata,
    input  logic [N-1:0]  dreq,
    output logic [N-1:0]  dack,
    output logic          hold_req,
    input  logic          hold_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          eop,
    output logic          irq
);
    localparam int PAD_W = AW - 2 * N;

    logic [N-1:0][AW-1:0]     addr_v;
    logic [N-1:0][CW-1:0]     cnt_v;
    logic [N-1:0][MODE_W-1:0] mode_v;
    logic [N-1:0]             done_v, tc_v;
    logic [N-1:0]             step_a, step_c, fdone;
    logic [N-1:0]             elig, sel_oh, irq_en;
    logic [N-1:0]             tc_stat;
    logic [IW-1:0]            ch_sel, pick_idx, cur_ch;
    logic [1:0]               fld;
    logic                     pick_any, is_m2m, last_dst, strobe;
    logic [DW-1:0]            tmp_q;
    seq_state_t               st;

    assign ch_sel   = cfg_addr[IW+1:2];
    assign fld      = cfg_addr[1:0];
    assign is_m2m   = mode_v[0][MB_M2M];
    assign last_dst = (cnt_v[1] == '0);
    assign sel_oh   = N'(1) << cur_ch;

    // Per-channel registers and their step controls.
    for (genvar i = 0; i < N; i++) begin : g_ch
        assign step_a[i] = ((st == S_XFER) && sel_oh[i]) ||
                           ((st == S_MRD) && (i == 0)) ||
                           ((st == S_MWR) && (i == 1));
        assign step_c[i] = ((st == S_XFER) && sel_oh[i]) ||
                           ((st == S_MWR) && (i == 1));
        assign fdone[i]  = (i == 0) && (st == S_MWR) && last_dst;
        assign irq_en[i] = mode_v[i][MB_IRQ];

        dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_addr    (cfg_wr && (ch_sel == IW'(i)) && (fld == FLD_ADDR)),
            .wr_cnt     (cfg_wr && (ch_sel == IW'(i)) && (fld == FLD_CNT)),
            .wr_mode    (cfg_wr && (ch_sel == IW'(i)) && (fld == FLD_MODE)),
            .wdata      (cfg_wdata),
            .step_addr  (step_a[i]),
            .step_cnt   (step_c[i]),
            .force_done (fdone[i]),
            .cur_addr   (addr_v[i]),
            .cur_cnt    (cnt_v[i]),
            .mode       (mode_v[i]),
            .done       (done_v[i]),
            .tc         (tc_v[i])
        );
    end

    // Eligible requests; in copy mode channel 1 is the destination only.
    always_comb begin
        for (int i = 0; i < N; i++)
            elig[i] = dreq[i] && mode_v[i][MB_EN] && !done_v[i];
        if (is_m2m) begin
            elig[1] = 1'b0;
            elig[0] = elig[0] && !done_v[1];
        end
    end

    dma_prio #(.N(N)) u_prio (
        .req (elig),
        .any (pick_any),
        .idx (pick_idx)
    );

    dma_seq #(.N(N)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .pick_m2m (is_m2m && (pick_idx == '0)),
        .hold_ack (hold_ack),
        .dreq_cur (dreq[cur_ch]),
        .last_dst (last_dst),
        .st       (st),
        .cur_ch   (cur_ch)
    );

    // Bus outputs derived from the sequencer state.
    always_comb begin
        mem_rd = ((st == S_XFER) && mode_v[cur_ch][MB_RD]) || (st == S_MRD);
        mem_wr = ((st == S_XFER) && !mode_v[cur_ch][MB_RD]) || (st == S_MWR);
        strobe = mem_rd || mem_wr;
        case (st)
            S_MRD:   mem_addr = addr_v[0];
            S_MWR:   mem_addr = addr_v[1];
            default: mem_addr = strobe ? addr_v[cur_ch] : '0;
        endcase
        mem_wdata = (st == S_MWR) ? tmp_q : '0;
        dack      = ((st == S_XFER) || (st == S_ACKW)) ? sel_oh : '0;
        hold_req  = (st != S_IDLE);
        eop       = ((st == S_XFER) && (cnt_v[cur_ch] == '0)) ||
                    ((st == S_MWR) && last_dst);
    end

    // Holding register for the copy read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tmp_q <= '0;
        else if (st == S_MRD)
            tmp_q <= mem_rdata;
    end

    // Sticky terminal-count flags, cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_stat <= '0;
        else if (cfg_rd && (fld == FLD_STAT))
            tc_stat <= tc_v;
        else
            tc_stat <= tc_stat | tc_v;
    end

    assign irq = |(tc_stat & irq_en);

    // Register read-back multiplexer.
    always_comb begin
        case (fld)
            FLD_ADDR: cfg_rdata = addr_v[ch_sel];
            FLD_CNT:  cfg_rdata = AW'(cnt_v[ch_sel]);
            FLD_MODE: cfg_rdata = AW'(mode_v[ch_sel]);
            default:  cfg_rdata = {{PAD_W{1'b0}}, done_v, tc_stat};
        endcase
    end
endmodule

// File: rtl/dma4_ctrl_chk.sv
// Protocol checker for dma4_ctrl, attached by bind. Assumes hold_ack
// only answers hold_req and requests stay up until acknowledged.
module dma4_ctrl_chk #(
    parameter int N  = 4,
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  dreq,
    input logic [N-1:0]  dack,
    input logic          hold_req,
    input logic          hold_ack,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic          eop
);
    // R4: a strobe only while the bus is requested and granted.
    a_r4_strobe_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (hold_req && hold_ack));

    // R4: an acknowledge never appears without the bus held.
    a_r4_dack_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack) |-> hold_req);

    // R5: never read and write in the same cycle.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R5: at most one channel acknowledged.
    a_r5_dack_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack));

    // R8: acknowledge holds while its request is still up.
    a_r8_dack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (|(dack & dreq)) |=> (dack == $past(dack)));

    // R7: end-of-process only during a word's strobe.
    a_r7_eop_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (mem_rd || mem_wr));
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.N(N), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dreq     (dreq),
    .dack     (dack),
    .hold_req (hold_req),
    .hold_ack (hold_ack),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .eop      (eop)
);

// File: tb/sim_dma4_ctrl.sv
// Self-checking bench for dma4_ctrl: a vector table of single peripheral
// words, then directed tests for reset, priority, terminal count and copy.
module sim_dma4_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [23:0] cfg_wdata = '0, cfg_rdata;
    logic [3:0]  dreq = '0, dack;
    logic        hold_req, hold_ack = 1'b0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr, eop, irq;
    logic [7:0]  mem_rdata, mem_wdata;
    int          n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;

    // Processor model: grant follows request by one cycle.
    always @(posedge clk) hold_ack <= rst_n ? hold_req : 1'b0;

    // Memory model for copy reads.
    assign mem_rdata = mem_addr[7:0] ^ 8'h5A;

    dma4_ctrl u0 (.*);

    // {ch[1:0], dec, rd, addr[23:0], cnt[15:0]}
    localparam logic [43:0] VEC [6] = '{
        {2'd0, 1'b0, 1'b0, 24'h000010, 16'h0005},
        {2'd1, 1'b1, 1'b1, 24'h000000, 16'h0003},
        {2'd2, 1'b0, 1'b0, 24'hFFFFFF, 16'h0001},
        {2'd3, 1'b1, 1'b0, 24'h123456, 16'h0100},
        {2'd0, 1'b0, 1'b1, 24'hABCDEF, 16'h0000},
        {2'd3, 1'b0, 1'b1, 24'h00FFFF, 16'h0002}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] ch, input logic [1:0] f, input logic [23:0] d);
        @(negedge clk);
        cfg_addr = {ch, f}; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] ch, input logic [1:0] f, input logic clr,
                            output logic [23:0] d);
        @(negedge clk);
        cfg_addr = {ch, f}; cfg_rd = clr;
        #1 d = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
    endtask

    // Wait at negedges for a strobe; flag dack or strobe seen early.
    task automatic wait_strobe(output bit seen);
        seen = 1'b0;
        for (int t = 0; t < 40 && !seen; t++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) begin
                seen = 1'b1;
                chk("R4 grant before strobe", hold_ack, 1'b1);
            end else if (dack != 0 && !hold_ack) begin
                chk("R4 dack before grant", dack, 0);
            end
        end
    endtask

    initial begin : watchdog
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [23:0] d;
        bit seen;
        repeat (3) @(negedge clk);
        // R1: outputs and registers at reset.
        chk("R1 outputs", {hold_req, dack, mem_rd, mem_wr, eop, irq}, 0);
        rst_n = 1'b1;
        cfg_read(2'd2, 2'd0, 1'b0, d); chk("R1 addr", d, 0);
        cfg_read(2'd2, 2'd1, 1'b0, d); chk("R1 count", d, 0);
        cfg_read(2'd1, 2'd2, 1'b0, d); chk("R1 mode", d, 0);

        // R2: write and read back each field.
        cfg_write(2'd3, 2'd0, 24'hA5A5A5);
        cfg_write(2'd3, 2'd1, 24'h001234);
        cfg_write(2'd3, 2'd2, 24'h00001F);
        cfg_read(2'd3, 2'd0, 1'b0, d); chk("R2 addr", d, 24'hA5A5A5);
        cfg_read(2'd3, 2'd1, 1'b0, d); chk("R2 count", d, 24'h001234);
        cfg_read(2'd3, 2'd2, 1'b0, d); chk("R2 mode", d, 24'h00001F);

        // R5 R6 R7 R8: vector table of single peripheral words.
        for (int k = 0; k < 6; k++) begin
            logic [43:0] v;
            logic [1:0]  ch;
            logic [23:0] a, ea;
            logic [15:0] c;
            v = VEC[k]; ch = v[43:42]; a = v[39:16]; c = v[15:0];
            ea = v[41] ? a - 24'd1 : a + 24'd1;
            cfg_write(ch, 2'd0, a);
            cfg_write(ch, 2'd1, {8'h0, c});
            cfg_write(ch, 2'd2, {21'h0, v[40], v[41], 1'b1});
            @(negedge clk); dreq[ch] = 1'b1;
            wait_strobe(seen);
            chk("R5 strobe seen", seen, 1'b1);
            chk("R5 address", mem_addr, a);
            chk("R5 direction", {mem_rd, mem_wr}, {v[40], ~v[40]});
            chk("R5 dack", dack, 4'(1) << ch);
            chk("R7 eop", eop, c == 16'h0);
            @(negedge clk);
            chk("R8 dack held", dack, 4'(1) << ch);
            dreq[ch] = 1'b0;
            @(negedge clk);
            chk("R8 release", {dack, hold_req}, 0);
            cfg_read(ch, 2'd0, 1'b0, d); chk("R6 address step", d, ea);
            cfg_read(ch, 2'd1, 1'b0, d); chk("R7 count step", d, {8'h0, c - 16'd1});
        end
        cfg_read(2'd0, 2'd3, 1'b1, d);

        // R7 R10: terminal count, stop, interrupt and status clear.
        cfg_write(2'd2, 2'd0, 24'h000040);
        cfg_write(2'd2, 2'd1, 24'h000000);
        cfg_write(2'd2, 2'd2, 24'h000009);
        @(negedge clk); dreq[2] = 1'b1;
        wait_strobe(seen);
        chk("R7 last word eop", eop, 1'b1);
        @(negedge clk); dreq[2] = 1'b0;
        @(negedge clk);
        chk("R10 irq set", irq, 1'b1);
        cfg_read(2'd2, 2'd1, 1'b0, d); chk("R7 rollover", d, 24'h00FFFF);
        @(negedge clk); dreq[2] = 1'b1;
        seen = 1'b0;
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            if (hold_req || mem_rd || mem_wr) seen = 1'b1;
        end
        chk("R7 stopped channel ignored", seen, 1'b0);
        dreq[2] = 1'b0;
        cfg_read(2'd0, 2'd3, 1'b1, d); chk("R10 status flags", d[3:0], 4'h4);
        chk("R10 stopped bits", d[6], 1'b1);
        cfg_read(2'd0, 2'd3, 1'b1, d); chk("R10 cleared", d[3:0], 4'h0);
        chk("R10 irq low", irq, 1'b0);

        // R3: disabled channel 0 ignored; channel 1 beats channel 3.
        cfg_write(2'd0, 2'd0, 24'h000500);
        cfg_write(2'd0, 2'd1, 24'h000009);
        cfg_write(2'd0, 2'd2, 24'h000000);
        cfg_write(2'd1, 2'd0, 24'h000600);
        cfg_write(2'd1, 2'd1, 24'h000009);
        cfg_write(2'd1, 2'd2, 24'h000001);
        cfg_write(2'd3, 2'd0, 24'h000700);
        cfg_write(2'd3, 2'd1, 24'h000009);
        cfg_write(2'd3, 2'd2, 24'h000001);
        @(negedge clk); dreq = 4'b1011;
        wait_strobe(seen);
        chk("R3 first winner", {dack, mem_addr}, {4'b0010, 24'h000600});
        @(negedge clk); dreq[1] = 1'b0;
        wait_strobe(seen);
        chk("R3 second winner", {dack, mem_addr}, {4'b1000, 24'h000700});
        @(negedge clk); dreq = 4'b0000;
        cfg_read(2'd0, 2'd0, 1'b0, d); chk("R3 disabled untouched", d, 24'h000500);

        // R9: block copy of three words from 0x100 to 0x200.
        cfg_write(2'd0, 2'd0, 24'h000100);
        cfg_write(2'd0, 2'd1, 24'h000007);
        cfg_write(2'd0, 2'd2, 24'h000011);
        cfg_write(2'd1, 2'd0, 24'h000200);
        cfg_write(2'd1, 2'd1, 24'h000002);
        cfg_write(2'd1, 2'd2, 24'h000001);
        @(negedge clk); dreq[0] = 1'b1;
        wait_strobe(seen);
        dreq[0] = 1'b0;
        for (int k = 0; k < 6; k++) begin
            logic [23:0] src;
            if (k > 0) @(negedge clk);
            src = 24'h000100 + 24'(k / 2);
            if (k % 2 == 0) begin
                chk("R9 read", {mem_rd, mem_wr, mem_addr}, {2'b10, src});
            end else begin
                chk("R9 write", {mem_rd, mem_wr, mem_addr}, {2'b01, 24'h000200 + 24'(k / 2)});
                chk("R9 data", mem_wdata, src[7:0] ^ 8'h5A);
            end
            chk("R9 bus held", {hold_req, eop, dack}, {1'b1, k == 5, 4'b0});
        end
        @(negedge clk);
        chk("R9 bus released", hold_req, 1'b0);
        cfg_read(2'd1, 2'd1, 1'b0, d); chk("R9 dest count", d, 24'h00FFFF);
        cfg_read(2'd0, 2'd1, 1'b0, d); chk("R9 source count kept", d, 24'h000007);
        cfg_read(2'd0, 2'd3, 1'b1, d); chk("R9 dest flag", d[3:0], 4'h2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule